// File: doc/BRIEF.md
# Flyback Transfer Pulse Scheduler

This block times the start pulses of a charge balancer built from four per-battery bidirectional flyback sections and one section on the balance bus. Each section has its own start-pulse output. A pulse opens one switching period; an external latch holds the switch on and an external comparator ends the on-time, so the block decides only when each period begins. In transfer mode, the caller gives the index of the battery with the highest voltage, the index of the one with the lowest voltage, and a length counted in switching periods. The block then pulses the high battery at the start of every period and the low battery half a period later, so that discharge and charge run in anti-phase. It stops by itself once the programmed number of periods has run.

A measurement mode pulses one chosen section, which may be the bus section, at one tenth of the switching rate. It raises a one-cycle ADC sample strobe at a fixed offset into each measurement period, chosen to fall near the middle of the flyback interval. Five voltage-condition inputs act in hardware. Any asserted condition blanks every start pulse in the same cycle and aborts the running job. It also latches a fault that turns the two-colour status from green to red. The four battery conditions also drive an active-low fault line to the charger directly.

Top module: `flyback_pulse_sched`

## Requirements
- R1: After reset, all pulse outputs, `busy`, `adc_strobe` and `cmd_err` are 0, `led_green` is 1 and `led_red` is 0.
- R2: In transfer mode (`mode`=0), section `a_idx` is high for PW_CYC cycles from phase 0 of each period of PER_CYC cycles. Section `b_idx` is high for PW_CYC cycles from phase PER_CYC/2. All other sections stay low. The first period begins in the first cycle after the clock edge that accepts the start.
- R3: A job of `dur` periods keeps `busy` high for exactly `dur` periods and then ends by itself, with no further pulses.
- R4: In measurement mode (`mode`=1), only section `a_idx` (0 to 3 for the batteries, 4 for the bus section) is pulsed, for PW_CYC cycles at phase 0 of each measurement period of PER_CYC*MEAS_MULT cycles.
- R5: `adc_strobe` is high for exactly one cycle, at phase SAMPLE_OFS of each measurement period, and never in transfer mode.
- R6: While any bit of `vcond` is high, every pulse output is 0 in that same cycle. A running job ends at the next clock edge.
- R7: `fault_n` is low exactly when any of `vcond[3:0]` is high, with no clock delay. `vcond[4]` (bus section) has no effect on it.
- R8: An asserted condition latches a fault: `led_red`=1, `led_green`=0. While the fault is latched, a start is rejected and sets `cmd_err`.
- R9: A fault from an input whose `hard_cfg` bit is 0 clears when `restart` is high while `vcond` is all 0. A `restart` while any condition is still high leaves the fault latched.
- R10: A fault from an input whose `hard_cfg` bit is 1 is not cleared by `restart`; only `rst` clears it.
- R11: A start is rejected and sets `cmd_err` in any of these cases: `dur`=0; in transfer mode, `a_idx`=`b_idx` or either index above 3; in measurement mode, `a_idx` above 4. A rejected start causes no pulse. The next accepted start clears `cmd_err`.
- R12: A start while `busy` is high is ignored: the running job keeps its sections and length, and `cmd_err` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start request, sampled on the clock edge |
| mode | input | 1 | 0 = transfer, 1 = measurement |
| a_idx | input | IDX_W | High battery (transfer) or measured section (measurement) |
| b_idx | input | IDX_W | Low battery (transfer only) |
| dur | input | DUR_W | Job length in periods |
| restart | input | 1 | Request to clear a recoverable fault |
| vcond | input | NCH | Voltage-condition inputs; bit 4 is the bus section |
| hard_cfg | input | NCH | Per input: 1 = its fault is non-recoverable |
| pulse | output | NCH | Start pulses, one per section |
| adc_strobe | output | 1 | ADC sample strobe |
| busy | output | 1 | A job is running |
| cmd_err | output | 1 | The last start was rejected |
| fault_n | output | 1 | Active-low battery fault line to the charger |
| led_green | output | 1 | Status: normal |
| led_red | output | 1 | Status: fault |

## Verification
The hardest state to reach from the ports is a condition input that rises in the middle of a start pulse, while the phase counter sits inside a pulse window. There the blanking has to act before the next edge, and the abort has to act on that edge. The bench starts a transfer, counts negative edges to a cycle where a pulse is known to be high, and raises a condition bit of a section outside the pair. It then samples a moment later in the same cycle. Random pairs, lengths and modes, plus a start injected in the middle of a job, show that the section choice stays latched once a job runs.

// File: rtl/fps_pkg.sv
package fps_pkg;
  typedef enum logic {
    JOB_XFER = 1'b0,
    JOB_MEAS = 1'b1
  } job_mode_e;
endpackage

// File: rtl/fps_cmd_check.sv
// Validates a start request against the section count and the job mode.
module fps_cmd_check
  import fps_pkg::*;
#(
  parameter int NBAT  = 4,
  parameter int IDX_W = 3,
  parameter int DUR_W = 8
) (
  input  job_mode_e          mode,
  input  logic [IDX_W-1:0]   a_idx,
  input  logic [IDX_W-1:0]   b_idx,
  input  logic [DUR_W-1:0]   dur,
  output logic               ok
);
  localparam logic [IDX_W-1:0] LAST_BAT = IDX_W'(NBAT - 1);
  localparam logic [IDX_W-1:0] BUS_SEL  = IDX_W'(NBAT);

  logic pair_ok, sel_ok;

  always_comb begin
    pair_ok = (a_idx <= LAST_BAT) && (b_idx <= LAST_BAT) && (a_idx != b_idx);
    sel_ok  = (a_idx <= BUS_SEL);
    ok      = (dur != '0) && ((mode == JOB_XFER) ? pair_ok : sel_ok);
  end
endmodule

// File: rtl/fps_phase_timer.sv
// Phase counter within a period, plus the count of remaining periods.
module fps_phase_timer #(
  parameter int PER_CYC   = 1250,
  parameter int MEAS_MULT = 10,
  parameter int DUR_W     = 8,
  localparam int MEAS_LEN = PER_CYC * MEAS_MULT,
  localparam int PH_W     = $clog2(MEAS_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             load_meas,
  input  logic [DUR_W-1:0] load_dur,
  input  logic             abort,
  output logic             busy,
  output logic             meas,
  output logic [PH_W-1:0]  ph
);
  localparam logic [PH_W-1:0] XFER_LAST = PH_W'(PER_CYC - 1);
  localparam logic [PH_W-1:0] MEAS_LAST = PH_W'(MEAS_LEN - 1);

  logic [DUR_W-1:0] left;
  logic [PH_W-1:0]  ph_last;

  assign ph_last = meas ? MEAS_LAST : XFER_LAST;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      meas <= 1'b0;
      ph   <= '0;
      left <= '0;
    end else if (abort) begin
      busy <= 1'b0;
      ph   <= '0;
    end else if (load) begin
      busy <= 1'b1;
      meas <= load_meas;
      ph   <= '0;
      left <= load_dur - DUR_W'(1);
    end else if (busy) begin
      if (ph == ph_last) begin
        ph <= '0;
        if (left == '0) busy <= 1'b0;
        else            left <= left - DUR_W'(1);
      end else begin
        ph <= ph + PH_W'(1);
      end
    end
  end
endmodule

// File: rtl/fps_pulse_decode.sv
// Decodes the phase into per-section start pulses and the sample strobe.
module fps_pulse_decode #(
  parameter int NCH        = 5,
  parameter int IDX_W      = 3,
  parameter int PH_W       = 14,
  parameter int PER_CYC    = 1250,
  parameter int PW_CYC     = 63,
  parameter int SAMPLE_OFS = 9000
) (
  input  logic             busy,
  input  logic             meas,
  input  logic [PH_W-1:0]  ph,
  input  logic [IDX_W-1:0] a_sel,
  input  logic [IDX_W-1:0] b_sel,
  input  logic             kill,
  output logic [NCH-1:0]   pulse,
  output logic             strobe
);
  localparam logic [PH_W-1:0] PW_L   = PH_W'(PW_CYC);
  localparam logic [PH_W-1:0] HALF_L = PH_W'(PER_CYC / 2);
  localparam logic [PH_W-1:0] HEND_L = PH_W'(PER_CYC / 2 + PW_CYC);
  localparam logic [PH_W-1:0] SMP_L  = PH_W'(SAMPLE_OFS);

  logic first_win, second_win;

  assign first_win  = (ph < PW_L);
  assign second_win = !meas && (ph >= HALF_L) && (ph < HEND_L);

  for (genvar ch = 0; ch < NCH; ch++) begin : g_sect
    logic hit_a, hit_b;
    assign hit_a     = (a_sel == IDX_W'(ch)) && first_win;
    assign hit_b     = (b_sel == IDX_W'(ch)) && second_win;
    assign pulse[ch] = busy && !kill && (hit_a || hit_b);
  end

  assign strobe = busy && meas && (ph == SMP_L);
endmodule

// File: rtl/fps_fault_ctrl.sv
// Sticky fault flags, status lamp and the charger fault line.
module fps_fault_ctrl #(
  parameter int NBAT = 4,
  parameter int NCH  = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] vcond,
  input  logic [NCH-1:0] hard_cfg,
  input  logic           restart,
  output logic           fault_any,
  output logic           fault_n,
  output logic           led_green,
  output logic           led_red
);
  logic soft_q, hard_q;
  logic soft_ev, hard_ev;

  assign soft_ev = |(vcond & ~hard_cfg);
  assign hard_ev = |(vcond & hard_cfg);

  always_ff @(posedge clk) begin
    if (rst) begin
      soft_q <= 1'b0;
      hard_q <= 1'b0;
    end else begin
      if (hard_ev) hard_q <= 1'b1;
      if (soft_ev)
        soft_q <= 1'b1;
      else if (restart && (vcond == '0) && !hard_q)
        soft_q <= 1'b0;
    end
  end

  assign fault_any = soft_q | hard_q;
  assign led_red   = fault_any;
  assign led_green = !fault_any;
  assign fault_n   = !(|vcond[NBAT-1:0]);
endmodule

// File: rtl/flyback_pulse_sched.sv
module flyback_pulse_sched
  import fps_pkg::*;
#(
  parameter int NBAT       = 4,
  parameter int IDX_W      = 3,
  parameter int DUR_W      = 8,
  parameter int PER_CYC    = 1250,
  parameter int PW_CYC     = 63,
  parameter int MEAS_MULT  = 10,
  parameter int SAMPLE_OFS = 9000,
  localparam int NCH       = NBAT + 1,
  localparam int PH_W      = $clog2(PER_CYC * MEAS_MULT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             mode,
  input  logic [IDX_W-1:0] a_idx,
  input  logic [IDX_W-1:0] b_idx,
  input  logic [DUR_W-1:0] dur,
  input  logic             restart,
  input  logic [NCH-1:0]   vcond,
  input  logic [NCH-1:0]   hard_cfg,
  output logic [NCH-1:0]   pulse,
  output logic             adc_strobe,
  output logic             busy,
  output logic             cmd_err,
  output logic             fault_n,
  output logic             led_green,
  output logic             led_red
);
  job_mode_e        req_mode;
  logic             kill, fault_any, req_ok, accept, meas;
  logic [PH_W-1:0]  ph;
  logic [IDX_W-1:0] a_q, b_q;

  assign req_mode = job_mode_e'(mode);
  assign kill     = |vcond;
  assign accept   = start && !busy && !fault_any && !kill && req_ok;

  fps_cmd_check #(.NBAT(NBAT), .IDX_W(IDX_W), .DUR_W(DUR_W)) u_cmd (
    .mode(req_mode), .a_idx(a_idx), .b_idx(b_idx), .dur(dur), .ok(req_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q     <= '0;
      b_q     <= '0;
      cmd_err <= 1'b0;
    end else if (accept) begin
      a_q     <= a_idx;
      b_q     <= b_idx;
      cmd_err <= 1'b0;
    end else if (start && !busy) begin
      cmd_err <= 1'b1;
    end
  end

  fps_phase_timer #(.PER_CYC(PER_CYC), .MEAS_MULT(MEAS_MULT), .DUR_W(DUR_W)) u_timer (
    .clk(clk), .rst(rst), .load(accept), .load_meas(req_mode == JOB_MEAS),
    .load_dur(dur), .abort(kill), .busy(busy), .meas(meas), .ph(ph)
  );

  fps_pulse_decode #(
    .NCH(NCH), .IDX_W(IDX_W), .PH_W(PH_W), .PER_CYC(PER_CYC),
    .PW_CYC(PW_CYC), .SAMPLE_OFS(SAMPLE_OFS)
  ) u_dec (
    .busy(busy), .meas(meas), .ph(ph), .a_sel(a_q), .b_sel(b_q),
    .kill(kill), .pulse(pulse), .strobe(adc_strobe)
  );

  fps_fault_ctrl #(.NBAT(NBAT), .NCH(NCH)) u_fault (
    .clk(clk), .rst(rst), .vcond(vcond), .hard_cfg(hard_cfg), .restart(restart),
    .fault_any(fault_any), .fault_n(fault_n), .led_green(led_green), .led_red(led_red)
  );
endmodule

// File: rtl/flyback_pulse_sched_chk.sv
module flyback_pulse_sched_chk #(
  parameter int NCH = 5
) (
  input logic           clk,
  input logic           rst,
  input logic [NCH-1:0] vcond,
  input logic [NCH-1:0] pulse,
  input logic           busy,
  input logic           adc_strobe,
  input logic           led_red,
  input logic           cmd_err
);
  p_blank_r6: assert property (@(posedge clk) disable iff (rst)
    (|vcond) |-> (pulse == '0));
  p_abort_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && |vcond) |=> !busy);
  p_antiphase_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pulse));
  p_strobe_busy_r5: assert property (@(posedge clk) disable iff (rst)
    adc_strobe |-> busy);
  p_latch_r8: assert property (@(posedge clk) disable iff (rst)
    (|vcond) |=> led_red);
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (led_red && !busy) |=> !busy);
  p_reject_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(cmd_err) |-> !$rose(busy));
endmodule

bind flyback_pulse_sched flyback_pulse_sched_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst(rst), .vcond(vcond), .pulse(pulse), .busy(busy),
  .adc_strobe(adc_strobe), .led_red(led_red), .cmd_err(cmd_err)
);

// File: tb/flyback_pulse_sched_tb.sv
module flyback_pulse_sched_tb;
  localparam int PER = 40, PW = 4, MM = 10, SOFS = 30;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, mode = 1'b0, restart = 1'b0;
  logic [2:0] a_idx = '0, b_idx = '0;
  logic [7:0] dur = '0;
  logic [4:0] vcond = '0, hard_cfg = '0;
  logic [4:0] pulse;
  logic adc_strobe, busy, cmd_err, fault_n, led_green, led_red;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  flyback_pulse_sched #(.DUR_W(8), .PER_CYC(PER), .PW_CYC(PW), .MEAS_MULT(MM),
                        .SAMPLE_OFS(SOFS)) u_dut (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .a_idx(a_idx), .b_idx(b_idx),
    .dur(dur), .restart(restart), .vcond(vcond), .hard_cfg(hard_cfg), .pulse(pulse),
    .adc_strobe(adc_strobe), .busy(busy), .cmd_err(cmd_err), .fault_n(fault_n),
    .led_green(led_green), .led_red(led_red)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] exp_pulse(input bit m, input int a, input int b, input int k);
    logic [4:0] v = '0;
    int ph = m ? (k % (PER * MM)) : (k % PER);
    if (ph < PW) v[a] = 1'b1;
    if (!m && ph >= PER / 2 && ph < PER / 2 + PW) v[b] = 1'b1;
    return v;
  endfunction

  function automatic bit exp_strobe(input bit m, input int k);
    return m && ((k % (PER * MM)) == SOFS);
  endfunction

  task automatic issue(input bit m, input int a, input int b, input int d);
    @(negedge clk);
    mode = m; a_idx = 3'(a); b_idx = 3'(b); dur = 8'(d); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // Runs a job and compares every cycle; poke >= 0 injects a start mid-job (R12).
  task automatic run_job(input bit m, input int a, input int b, input int d, input int poke);
    int bad = 0;
    logic [31:0] act = 0, expv = 0;
    int total = d * (m ? PER * MM : PER);
    issue(m, a, b, d);
    for (int k = 0; k < total; k++) begin
      logic [4:0] e = exp_pulse(m, a, b, k);
      if (k == poke) begin start = 1'b1; mode = ~m; a_idx = 3'((a + 2) % 4); b_idx = 3'((a + 3) % 4); end
      if (k == poke + 1) start = 1'b0;
      if (pulse !== e || adc_strobe !== exp_strobe(m, k) || busy !== 1'b1) begin
        if (bad == 0) begin act = {busy, adc_strobe, pulse}; expv = {1'b1, exp_strobe(m, k), e}; end
        bad++;
      end
      @(negedge clk);
    end
    start = 1'b0;
    chk(bad == 0, m ? "R4 R5 measurement pulses/strobe" : "R2 transfer anti-phase pulses", act, expv);
    chk(busy == 1'b0, "R3 job ends after dur periods", busy, 0);
    repeat (5) @(negedge clk);
    chk(pulse == '0 && !busy, "R3 no pulses after end", pulse, 0);
    if (poke >= 0) chk(cmd_err == 1'b0, "R12 start while busy ignored", cmd_err, 0);
  endtask

  task automatic expect_reject(input bit m, input int a, input int b, input int d, input string tag);
    issue(m, a, b, d);
    chk(cmd_err == 1'b1 && busy == 1'b0, tag, {busy, cmd_err}, 1);
    repeat (3) @(negedge clk);
    chk(pulse == '0 && !busy, tag, pulse, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(pulse == '0 && !busy && !adc_strobe && !cmd_err, "R1 reset outputs",
        {busy, adc_strobe, cmd_err, pulse}, 0);
    chk(led_green && !led_red && fault_n, "R1 reset status", {led_green, led_red, fault_n}, 3'b101);

    // Directed jobs
    run_job(0, 3, 0, 2, -1);
    run_job(1, 4, 0, 2, -1);
    run_job(0, 0, 1, 3, 5);

    // Constrained random valid jobs
    for (int it = 0; it < 20; it++) begin
      bit m = ($urandom % 4) == 0;
      int a = m ? int'($urandom % 5) : int'($urandom % 4);
      int b = (a % 4 + 1 + int'($urandom % 3)) % 4;
      int d = m ? 1 : 1 + int'($urandom % 3);
      if (!m && a == b) b = (a + 1) % 4;
      run_job(m, a, b, d, -1);
    end

    // R11 rejected commands
    expect_reject(0, 2, 2, 2, "R11 equal pair rejected");
    expect_reject(0, 4, 1, 2, "R11 bus index in transfer rejected");
    expect_reject(1, 5, 0, 1, "R11 measurement index 5 rejected");
    expect_reject(0, 1, 2, 0, "R11 zero length rejected");
    issue(0, 1, 2, 1);
    chk(cmd_err == 1'b0 && busy, "R11 accepted start clears error", cmd_err, 0);
    repeat (PER + 2) @(negedge clk);

    // R6 blanking in the middle of a pulse, then R8 fault latch
    issue(0, 1, 2, 4);
    repeat (41) @(negedge clk);
    chk(pulse == 5'b00010, "R2 pulse high before condition", pulse, 5'b00010);
    vcond = 5'b00001;
    #1;
    chk(pulse == '0, "R6 same-cycle blanking", pulse, 0);
    chk(fault_n == 1'b0, "R7 battery condition drives fault line", fault_n, 0);
    @(negedge clk);
    chk(!busy, "R6 job aborted", busy, 0);
    chk(led_red && !led_green, "R8 fault latched", {led_red, led_green}, 2'b10);
    vcond = 5'b10000;
    #1;
    chk(fault_n == 1'b1, "R7 bus condition excluded", fault_n, 1);
    @(negedge clk);
    vcond = 5'b00000;
    expect_reject(0, 0, 1, 1, "R8 start rejected during fault");

    // R9 recoverable clear
    vcond = 5'b01000;
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    chk(led_red == 1'b1, "R9 restart with condition high keeps fault", led_red, 1);
    vcond = '0;
    @(negedge clk);
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    chk(led_green && !led_red, "R9 restart clears recoverable fault", led_green, 1);
    run_job(0, 2, 3, 1, -1);

    // R10 non-recoverable fault
    hard_cfg = 5'b00100;
    vcond = 5'b00100;
    @(negedge clk);
    vcond = '0;
    @(negedge clk);
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    @(negedge clk);
    chk(led_red == 1'b1, "R10 restart cannot clear hard fault", led_red, 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(led_green && !led_red, "R10 reset clears hard fault", led_green, 1);

    finished = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule